// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block performs integer multiplication and division over many clock cycles. It writes each result into two dedicated result registers that sit outside the general register file. A multiply leaves the upper half of the double-width product in the high register and the lower half in the low register. A divide leaves the remainder in the high register and the quotient in the low register. The two registers are read through their own output ports, which stand in for the move-from-high and move-from-low operations.

A command is offered with `cmd_valid` together with an operation code and two operands. The command is taken on the rising edge where both `cmd_valid` and `cmd_ready` are high. While an operation is in flight, `cmd_ready` is low and the unit does not accept a command: a requester must hold its command until `cmd_ready` returns. The multiply path adds the shifted multiplicand once for each set multiplier bit. The divide path is a restoring divider. Both paths work on magnitudes, and a final cycle applies the signs and loads both result registers.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 2'b00 (signed multiply) leaves {hi_out, lo_out} equal to the 64-bit two's-complement product of the signed operands.
- R2: Operation code 2'b01 (signed divide) with a nonzero divisor leaves lo_out = quotient truncated toward zero and hi_out = remainder with the sign of the dividend, so that quotient × divisor + remainder equals the dividend.
- R3: With HAS_UNSIGNED = 1, operation code 2'b10 is an unsigned multiply and 2'b11 is an unsigned divide, with the same hi/lo placement as R1 and R2.
- R4: A divide by zero completes with the normal latency and leaves lo_out all ones and hi_out equal to the dividend.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF leaves lo_out = 0x80000000 and hi_out = 0.
- R6: After an accepting edge, busy is high and cmd_ready is low for exactly WIDTH+1 cycles. hi_out and lo_out take their new values on the edge where busy falls.
- R7: A cmd_valid raised while busy is ignored: the in-flight result is unchanged and no further operation starts.
- R8: After reset, busy is 0, cmd_ready is 1, and hi_out and lo_out are 0. The result registers keep their values while no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command (idle) |
| cmd_op | input | 2 | 00 mul signed, 01 div signed, 10 mul unsigned, 11 div unsigned |
| cmd_a | input | WIDTH | Multiplicand or dividend |
| cmd_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| hi_out | output | WIDTH | High result register (product upper half or remainder) |
| lo_out | output | WIDTH | Low result register (product lower half or quotient) |

## Verification
The bench builds the unit with WIDTH = 32 and HAS_UNSIGNED = 1. This configuration exposes both signed and unsigned operation codes. It also puts the 64-bit product and the 0x80000000 boundary within reach of exact 64-bit reference arithmetic in the bench. Directed cases cover divide by zero for both dividend signs, the most negative value divided by minus one, and all-ones operands. Random commands mix full-range and small operands, and each result is checked against the reference and against the division identity.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_DIV_S = 2'b01,
    OP_MUL_U = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/muldiv_prep.sv
`timescale 1ns/1ps
// Operand conditioning: magnitudes and result sign flags
module muldiv_prep #(
  parameter int WIDTH        = 32,
  parameter bit HAS_UNSIGNED = 1'b1
) (
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             is_div,
  output logic [WIDTH-1:0] a_mag,
  output logic [WIDTH-1:0] b_mag,
  output logic             neg_main,
  output logic             neg_rem,
  output logic             b_zero
);
  logic signed_op;
  logic a_neg, b_neg;

  generate
    if (HAS_UNSIGNED) begin : g_uns
      assign signed_op = ~op[1];
    end else begin : g_sgn
      assign signed_op = 1'b1;
    end
  endgenerate

  assign is_div   = op[0];
  assign a_neg    = signed_op & a[WIDTH-1];
  assign b_neg    = signed_op & b[WIDTH-1];
  assign a_mag    = a_neg ? (~a + 1'b1) : a;
  assign b_mag    = b_neg ? (~b + 1'b1) : b;
  assign neg_main = a_neg ^ b_neg;
  assign neg_rem  = a_neg;
  assign b_zero   = (b == '0);
endmodule

// File: rtl/muldiv_mul_core.sv
`timescale 1ns/1ps
// Shift-and-add multiplier, one multiplier bit per step
module muldiv_mul_core #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] prod
);
  logic [WIDTH-1:0] mc_q, acc_q, sh_q;
  logic [WIDTH:0]   sum;

  assign sum  = {1'b0, acc_q} + (sh_q[0] ? {1'b0, mc_q} : '0);
  assign prod = {acc_q, sh_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q  <= '0;
      acc_q <= '0;
      sh_q  <= '0;
    end else if (load) begin
      mc_q  <= mcand;
      acc_q <= '0;
      sh_q  <= mplier;
    end else if (step) begin
      {acc_q, sh_q} <= {sum, sh_q[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_div_core.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per step
module muldiv_div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);
  logic [WIDTH-1:0] dv_q, rem_q, quo_q;
  logic [WIDTH:0]   shifted, trial;

  assign shifted = {rem_q, quo_q[WIDTH-1]};
  assign trial   = shifted - {1'b0, dv_q};
  assign quo     = quo_q;
  assign rem     = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      dv_q  <= divisor;
      rem_q <= '0;
      quo_q <= dividend;
    end else if (step) begin
      if (!trial[WIDTH]) begin
        rem_q <= trial[WIDTH-1:0];
        quo_q <= {quo_q[WIDTH-2:0], 1'b1};
      end else begin
        rem_q <= shifted[WIDTH-1:0];
        quo_q <= {quo_q[WIDTH-2:0], 1'b0};
      end
    end
  end

  // R2: partial remainder always stays below a nonzero divisor
  p_rem_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dv_q != '0) |=> (rem_q < dv_q));
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit #(
  parameter int WIDTH        = 32,
  parameter bit HAS_UNSIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_a,
  input  logic [WIDTH-1:0] cmd_b,
  output logic             busy,
  output logic [WIDTH-1:0] hi_out,
  output logic [WIDTH-1:0] lo_out
);
  import muldiv_pkg::*;

  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  md_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  logic             accept, step;
  logic             p_is_div, p_neg_main, p_neg_rem, p_b_zero;
  logic [WIDTH-1:0] p_a_mag, p_b_mag;
  logic             is_div_q, neg_main_q, neg_rem_q, b_zero_q;
  logic [WIDTH-1:0] a_raw_q, hi_q, lo_q;
  logic [2*WIDTH-1:0] prod, prod_s;
  logic [WIDTH-1:0] quo, rem, quo_s, rem_s, hi_d, lo_d;

  assign busy      = (state_q != ST_IDLE);
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  assign step      = (state_q == ST_RUN);
  assign hi_out    = hi_q;
  assign lo_out    = lo_q;

  muldiv_prep #(.WIDTH(WIDTH), .HAS_UNSIGNED(HAS_UNSIGNED)) u_prep (
    .op(cmd_op), .a(cmd_a), .b(cmd_b),
    .is_div(p_is_div), .a_mag(p_a_mag), .b_mag(p_b_mag),
    .neg_main(p_neg_main), .neg_rem(p_neg_rem), .b_zero(p_b_zero)
  );

  muldiv_mul_core #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .mcand(p_a_mag), .mplier(p_b_mag), .prod(prod)
  );

  muldiv_div_core #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
    .dividend(p_a_mag), .divisor(p_b_mag), .quo(quo), .rem(rem)
  );

  // Sign fix-up and result selection
  always_comb begin
    prod_s = neg_main_q ? (~prod + 1'b1) : prod;
    quo_s  = neg_main_q ? (~quo + 1'b1)  : quo;
    rem_s  = neg_rem_q  ? (~rem + 1'b1)  : rem;
    if (!is_div_q) begin
      hi_d = prod_s[2*WIDTH-1:WIDTH];
      lo_d = prod_s[WIDTH-1:0];
    end else if (b_zero_q) begin
      hi_d = a_raw_q;
      lo_d = '1;
    end else begin
      hi_d = rem_s;
      lo_d = quo_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      is_div_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      b_zero_q   <= 1'b0;
      a_raw_q    <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          state_q    <= ST_RUN;
          cnt_q      <= '0;
          is_div_q   <= p_is_div;
          neg_main_q <= p_neg_main;
          neg_rem_q  <= p_neg_rem;
          b_zero_q   <= p_b_zero;
          a_raw_q    <= cmd_a;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          hi_q    <= hi_d;
          lo_q    <= lo_d;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6: an accepted command makes the unit busy on the next cycle
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R6: busy only rises because a command was offered
  p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R7: iteration runs to its end regardless of new commands
  p_run_continue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cnt_q != LAST) |=> (state_q == ST_RUN));
  // R8: result registers change only in the fix-up cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FIX) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [W-1:0] cmd_a = '0, cmd_b = '0;
  logic cmd_ready, busy;
  logic [W-1:0] hi_out, lo_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  muldiv_unit #(.WIDTH(W), .HAS_UNSIGNED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] res;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b00: res = sa * sb;
      2'b10: res = {32'b0, a} * {32'b0, b};
      default: begin
        if (b == 0) res = {a, 32'hFFFF_FFFF};
        else if (op == 2'b01) begin
          q = sa / sb;
          r = sa % sb;
          res = {r[31:0], q[31:0]};
        end else res = {a % b, a / b};
      end
    endcase
    return res;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag, input bit intrude);
    int n;
    logic [63:0] exp;
    exp = model(op, a, b);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R6 ready before command", {63'b0, cmd_ready}, 64'd1);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (intrude && n == 3) begin
        cmd_valid = 1'b1; cmd_op = op ^ 2'b01; cmd_a = ~a; cmd_b = b + 1;
      end
      if (n == 6) cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk(n == W + 1, "R6 busy length", 64'(n), 64'(W + 1));
    chk({hi_out, lo_out} == exp, tag, {hi_out, lo_out}, exp);
    if (intrude) begin
      @(negedge clk);
      chk(busy == 1'b0, "R7 no extra command taken", {63'b0, busy}, 64'd0);
    end
  endtask

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R8 reset handshake",
        {62'b0, busy, cmd_ready}, 64'd1);
    chk({hi_out, lo_out} == 64'd0, "R8 reset results", {hi_out, lo_out}, 64'd0);
    rst_n = 1'b1;

    run_op(2'b00, 32'd7, 32'hFFFF_FFFD, "R1 mul 7*-3", 1'b0);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R1 mul min*min", 1'b0);
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mul -1*-1", 1'b0);
    run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, "R1 mul max*min", 1'b0);
    run_op(2'b01, 32'hFFFF_FFF9, 32'd2, "R2 div -7/2", 1'b0);
    run_op(2'b01, 32'd7, 32'hFFFF_FFFE, "R2 div 7/-2", 1'b0);
    run_op(2'b01, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R2 div -7/-2", 1'b0);
    run_op(2'b01, 32'hFFFF_FFFB, 32'd0, "R4 div -5/0", 1'b0);
    run_op(2'b01, 32'd123, 32'd0, "R4 div 123/0", 1'b0);
    run_op(2'b11, 32'hFFFF_FFFB, 32'd0, "R4 udiv by zero", 1'b0);
    run_op(2'b01, 32'h8000_0000, 32'hFFFF_FFFF, "R5 div min/-1", 1'b0);
    run_op(2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 umul all ones", 1'b0);
    run_op(2'b11, 32'hFFFF_FFFF, 32'd2, "R3 udiv big", 1'b0);
    run_op(2'b01, 32'd1000, 32'd7, "R7 result kept under intrusion", 1'b1);

    // R8: idle input activity must not touch the result registers
    keep = {hi_out, lo_out};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cmd_a = $urandom; cmd_b = $urandom; cmd_op = 2'($urandom);
    end
    @(negedge clk);
    chk({hi_out, lo_out} == keep, "R8 results held while idle", {hi_out, lo_out}, keep);

    for (int i = 0; i < 80; i++) begin
      logic [1:0] op;
      logic [31:0] a, b;
      op = 2'($urandom);
      a = ($urandom % 3 == 0) ? 32'($signed(8'($urandom))) : $urandom;
      b = ($urandom % 3 == 0) ? 32'($signed(6'($urandom))) : $urandom;
      case (op)
        2'b00: run_op(op, a, b, "R1 random mul", 1'b0);
        2'b01: run_op(op, a, b, "R2 random div", 1'b0);
        default: run_op(op, a, b, "R3 random unsigned", 1'b0);
      endcase
      if (op == 2'b01 && b != 0)
        chk(lo_out * b + hi_out == a, "R2 identity",
            {32'b0, lo_out * b + hi_out}, {32'b0, a});
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule